// File: doc/BRIEF.md
# Shifted Register Operand Unit

This unit forms the second source operand of a 32-bit RISC data-processing or load/store instruction. From the instruction word it decodes which register supplies the operand and which register (if any) supplies a shift amount. It then applies one of four shift kinds to the operand value and produces both the shifted value and the shifter's carry-out. Two amount sources are supported: a 5-bit immediate amount in the instruction, and a register amount taken from the low byte of a second register value.

The immediate form carries the subtle part. An amount of zero is not a plain "no shift" for every kind. For a logical left shift it is a pass-through. For logical and arithmetic right shifts it stands for a shift by the full word width. For rotate right it selects a one-bit rotate through the incoming carry flag. For load/store instructions the unit also picks between a 12-bit immediate offset and a shifted-register offset, and it reports whether the offset is added to the base or subtracted from it.

The register indices are decoded combinationally, so they can address a register file in the same cycle. The operand, the shifter carry, the updated carry flag and the add/subtract select are registered one clock after the inputs.

Top module: `sro_unit`

## Requirements
- R1: While `rst_ni` is low, `operand_o`, `shift_carry_o`, `carry_o` and `offset_add_o` are 0. Outside reset, these outputs show the result of the inputs sampled at the previous rising clock edge.
- R2: `rm_idx_o` equals instruction bits 3:0 and `rs_idx_o` equals bits 11:8, both combinationally. The shift kind is bits 6:5 (0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right). The immediate amount is bits 11:7. For a data-processing instruction (`ldst_i` low), bit 4 set selects the register amount.
- R3: Immediate logical left by n: n = 0 passes the operand unchanged and the shifter carry equals `carry_i`. For n > 0, the result is operand << n and the carry is operand bit 32-n.
- R4: Immediate logical right: n = 0 acts as a shift by 32, giving zero with carry = operand bit 31. For n > 0, the result is operand >> n and the carry is operand bit n-1.
- R5: Immediate arithmetic right: n = 0 acts as a shift by 32, so every result bit and the carry equal operand bit 31. For n > 0, the result is the sign-filling shift and the carry is operand bit n-1.
- R6: Immediate rotate right: n = 0 gives {carry_i, operand[31:1]} with carry = operand bit 0. For n > 0, the result is the rotate by n and the carry is operand bit n-1.
- R7: Register amount a = `rs_val_i[7:0]`. If a = 0, the operand passes unchanged and the carry equals `carry_i`. Logical left or right with a = 32 gives zero with carry = bit 0 (left) or bit 31 (right). With a > 32, both give zero with carry 0. Arithmetic right with a >= 32 fills every bit and the carry with bit 31. Rotate with a nonzero and a[4:0] = 0 leaves the operand unchanged with carry = bit 31. Any other rotate is by a[4:0].
- R8: `carry_o` equals the shifter carry when `logic_cc_i` is high and `ldst_i` is low. Otherwise it equals `carry_i`.
- R9: With `ldst_i` high and bit 25 clear, the operand is instruction bits 11:0 zero-extended and the shifter carry is `carry_i`. With bit 25 set, the immediate-amount shift applies and bit 4 is ignored.
- R10: `offset_add_o` equals instruction bit 23 when `ldst_i` is high (1 add, 0 subtract), and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ldst_i | input | 1 | Instruction is a load/store |
| logic_cc_i | input | 1 | Instruction is a flag-setting logical operation |
| instr_i | input | 32 | Instruction word |
| rm_val_i | input | 32 | Value of the operand register |
| rs_val_i | input | 32 | Value of the shift-amount register |
| carry_i | input | 1 | Current carry flag |
| rm_idx_o | output | 4 | Operand register index |
| rs_idx_o | output | 4 | Shift-amount register index |
| operand_o | output | 32 | Shifted operand (registered) |
| shift_carry_o | output | 1 | Shifter carry-out (registered) |
| carry_o | output | 1 | Carry flag after this instruction (registered) |
| offset_add_o | output | 1 | Load/store offset is added (registered) |

## Verification
The bench targets zero immediate amounts for each shift kind. A design that treated them as no shift would pass logical and arithmetic right shifts through unchanged, and would leave a zero rotate untouched instead of pulling the carry into bit 31. It also checks the carry at the edge amounts 1 and 31, where an off-by-one bit index shows up at once. Register amounts of 32, 33, 64 and 255 are covered, where a shifter that truncates the amount to five bits would wrap. It checks that flag updates are blocked for non-logical and load/store instructions, and that the load/store immediate offset is zero-extended rather than shifted.

// File: rtl/sro_pkg.sv
package sro_pkg;
    localparam int unsigned INSTR_W   = 32;
    localparam int unsigned IDX_W     = 4;
    localparam int unsigned OFF_W     = 12;
    localparam int unsigned RM_LSB    = 0;
    localparam int unsigned RS_LSB    = 8;
    localparam int unsigned REGSH_BIT = 4;
    localparam int unsigned KIND_LSB  = 5;
    localparam int unsigned AMT_LSB   = 7;
    localparam int unsigned UP_BIT    = 23;
    localparam int unsigned REGOFF_BIT = 25;

    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } sh_kind_e;
endpackage

// File: rtl/sro_barrel.sv
module sro_barrel
    import sro_pkg::*;
#(
    parameter int unsigned W     = 32,
    parameter int unsigned AMT_W = 8
) (
    input  sh_kind_e         kind_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic [W-1:0]     x_i,
    input  logic             cin_i,
    output logic [W-1:0]     res_o,
    output logic             cout_o
);
    localparam int unsigned SH_W = $clog2(W);

    logic [2*W-1:0] wide_l;
    logic [2*W-1:0] wide_r;
    logic [2*W-1:0] wide_a;
    logic [2*W-1:0] wide_rot;
    logic [SH_W-1:0] rot_amt;

    always_comb begin
        wide_l   = {{W{1'b0}}, x_i} << amt_i;
        wide_r   = {x_i, {W{1'b0}}} >> amt_i;
        wide_a   = $signed({x_i, {W{1'b0}}}) >>> amt_i;
        rot_amt  = amt_i[SH_W-1:0];
        wide_rot = {x_i, x_i} >> rot_amt;
        res_o    = x_i;
        cout_o   = cin_i;
        if (amt_i != '0) begin
            unique case (kind_i)
                SH_LSL: begin
                    res_o  = wide_l[W-1:0];
                    cout_o = wide_l[W];
                end
                SH_LSR: begin
                    res_o  = wide_r[2*W-1:W];
                    cout_o = wide_r[W-1];
                end
                SH_ASR: begin
                    res_o  = wide_a[2*W-1:W];
                    cout_o = wide_a[W-1];
                end
                default: begin
                    res_o  = wide_rot[W-1:0];
                    cout_o = wide_rot[W-1];
                end
            endcase
        end
    end
endmodule

// File: rtl/sro_imm_shift.sv
module sro_imm_shift
    import sro_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  sh_kind_e                 kind_i,
    input  logic [$clog2(W)-1:0]     amt_i,
    input  logic [W-1:0]             x_i,
    input  logic                     cin_i,
    output logic [W-1:0]             res_o,
    output logic                     cout_o
);
    localparam int unsigned SH_W  = $clog2(W);
    localparam int unsigned EXT_W = SH_W + 1;

    logic [EXT_W-1:0] amt_ext;
    logic [W-1:0]     b_res;
    logic             b_cout;
    logic             is_rrx;

    always_comb begin
        amt_ext = {1'b0, amt_i};
        if ((kind_i == SH_LSR || kind_i == SH_ASR) && amt_i == '0) begin
            amt_ext = EXT_W'(W);
        end
    end

    sro_barrel #(.W(W), .AMT_W(EXT_W)) i_barrel (
        .kind_i (kind_i),
        .amt_i  (amt_ext),
        .x_i    (x_i),
        .cin_i  (cin_i),
        .res_o  (b_res),
        .cout_o (b_cout)
    );

    always_comb begin
        is_rrx = (kind_i == SH_ROR) && (amt_i == '0);
        res_o  = is_rrx ? {cin_i, x_i[W-1:1]} : b_res;
        cout_o = is_rrx ? x_i[0] : b_cout;
    end
endmodule

// File: rtl/sro_unit.sv
module sro_unit
    import sro_pkg::*;
#(
    parameter int unsigned W        = 32,
    parameter int unsigned RS_AMT_W = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               ldst_i,
    input  logic               logic_cc_i,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [W-1:0]       rm_val_i,
    input  logic [W-1:0]       rs_val_i,
    input  logic               carry_i,
    output logic [IDX_W-1:0]   rm_idx_o,
    output logic [IDX_W-1:0]   rs_idx_o,
    output logic [W-1:0]       operand_o,
    output logic               shift_carry_o,
    output logic               carry_o,
    output logic               offset_add_o
);
    localparam int unsigned SH_W = $clog2(W);

    typedef struct packed {
        logic [W-1:0] operand;
        logic         shc;
        logic         flag;
        logic         add;
    } out_t;

    out_t out_d, out_q;

    sh_kind_e        kind;
    logic [SH_W-1:0] imm_amt;
    logic [W-1:0]    imm_res, reg_res;
    logic            imm_cout, reg_cout;
    logic            use_reg, imm_off;
    logic            unused_bits;

    assign unused_bits = ^{instr_i[31:26], instr_i[24], instr_i[22:12], rs_val_i[W-1:RS_AMT_W]};

    assign rm_idx_o = instr_i[RM_LSB +: IDX_W];
    assign rs_idx_o = instr_i[RS_LSB +: IDX_W];
    assign kind     = sh_kind_e'(instr_i[KIND_LSB +: 2]);
    assign imm_amt  = instr_i[AMT_LSB +: SH_W];

    sro_imm_shift #(.W(W)) i_imm (
        .kind_i (kind),
        .amt_i  (imm_amt),
        .x_i    (rm_val_i),
        .cin_i  (carry_i),
        .res_o  (imm_res),
        .cout_o (imm_cout)
    );

    sro_barrel #(.W(W), .AMT_W(RS_AMT_W)) i_reg (
        .kind_i (kind),
        .amt_i  (rs_val_i[RS_AMT_W-1:0]),
        .x_i    (rm_val_i),
        .cin_i  (carry_i),
        .res_o  (reg_res),
        .cout_o (reg_cout)
    );

    always_comb begin
        use_reg = !ldst_i && instr_i[REGSH_BIT];
        imm_off = ldst_i && !instr_i[REGOFF_BIT];
        if (imm_off) begin
            out_d.operand = W'(instr_i[OFF_W-1:0]);
            out_d.shc     = carry_i;
        end else if (use_reg) begin
            out_d.operand = reg_res;
            out_d.shc     = reg_cout;
        end else begin
            out_d.operand = imm_res;
            out_d.shc     = imm_cout;
        end
        out_d.flag = (logic_cc_i && !ldst_i) ? out_d.shc : carry_i;
        out_d.add  = ldst_i && instr_i[UP_BIT];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) out_q <= '0;
        else         out_q <= out_d;
    end

    assign operand_o     = out_q.operand;
    assign shift_carry_o = out_q.shc;
    assign carry_o       = out_q.flag;
    assign offset_add_o  = out_q.add;

    assert_lsl_zero_pass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $past(!ldst_i && !instr_i[4] && instr_i[6:5] == 2'd0 && instr_i[11:7] == 5'd0))
        |-> (operand_o == $past(rm_val_i) && shift_carry_o == $past(carry_i)));

    assert_lsr_zero_full_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $past(!ldst_i && !instr_i[4] && instr_i[6:5] == 2'd1 && instr_i[11:7] == 5'd0))
        |-> (operand_o == '0 && shift_carry_o == $past(rm_val_i[W-1])));

    assert_asr_zero_sign_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $past(!ldst_i && !instr_i[4] && instr_i[6:5] == 2'd2 && instr_i[11:7] == 5'd0))
        |-> (operand_o == {W{$past(rm_val_i[W-1])}} && shift_carry_o == $past(rm_val_i[W-1])));

    assert_rrx_carry_in_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $past(!ldst_i && !instr_i[4] && instr_i[6:5] == 2'd3 && instr_i[11:7] == 5'd0))
        |-> (operand_o == {$past(carry_i), $past(rm_val_i[W-1:1])} && shift_carry_o == $past(rm_val_i[0])));

    assert_reg_amt_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $past(!ldst_i && instr_i[4] && rs_val_i[RS_AMT_W-1:0] == '0))
        |-> (operand_o == $past(rm_val_i) && shift_carry_o == $past(carry_i)));

    assert_flag_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $past(!(logic_cc_i && !ldst_i)))
        |-> (carry_o == $past(carry_i)));

    assert_ldst_imm_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni) && $past(ldst_i && !instr_i[25]))
        |-> (operand_o == W'($past(instr_i[11:0])) && shift_carry_o == $past(carry_i)));

    assert_offset_dir_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) |-> (offset_add_o == $past(ldst_i && instr_i[23])));
endmodule

// File: tb/test_sro_unit.sv
`timescale 1ns/1ps
module test_sro_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ldst = 1'b0, cc = 1'b0, cin = 1'b0;
    logic [31:0] instr = '0, rm = '0, rs = '0;
    logic [3:0]  rm_idx, rs_idx;
    logic [31:0] operand;
    logic        shc, flag, add;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct packed {
        logic [31:0] op;
        logic        sc;
        logic        fl;
        logic        ad;
    } exp_t;

    always #2 clk = ~clk;

    sro_unit i_sro_unit (
        .clk_i(clk), .rst_ni(rst_n), .ldst_i(ldst), .logic_cc_i(cc),
        .instr_i(instr), .rm_val_i(rm), .rs_val_i(rs), .carry_i(cin),
        .rm_idx_o(rm_idx), .rs_idx_o(rs_idx), .operand_o(operand),
        .shift_carry_o(shc), .carry_o(flag), .offset_add_o(add)
    );

    function automatic exp_t model(input logic [31:0] ins, x, r, input logic ci, c_en, ls);
        exp_t e;
        logic [1:0] k = ins[6:5];
        logic regsh = !ls && ins[4];
        int n;
        int m;
        logic [31:0] res = '0;
        logic c = ci;
        if (ls && !ins[25]) begin
            res = {20'd0, ins[11:0]};
            c = ci;
        end else if (!regsh && k == 2'd3 && ins[11:7] == 5'd0) begin
            res = {ci, x[31:1]};
            c = x[0];
        end else begin
            if (regsh) n = int'(r[7:0]);
            else begin
                n = int'(ins[11:7]);
                if (n == 0 && (k == 2'd1 || k == 2'd2)) n = 32;
            end
            if (n == 0) begin
                res = x;
                c = ci;
            end else begin
                case (k)
                    2'd0: begin
                        for (int i = 0; i < 32; i++) res[i] = (i - n >= 0) ? x[i-n] : 1'b0;
                        c = (n <= 32) ? x[32-n] : 1'b0;
                    end
                    2'd1: begin
                        for (int i = 0; i < 32; i++) res[i] = (i + n < 32) ? x[i+n] : 1'b0;
                        c = (n <= 32) ? x[n-1] : 1'b0;
                    end
                    2'd2: begin
                        for (int i = 0; i < 32; i++) res[i] = (i + n < 32) ? x[i+n] : x[31];
                        c = (n <= 32) ? x[n-1] : x[31];
                    end
                    default: begin
                        m = n % 32;
                        if (m == 0) begin
                            res = x;
                            c = x[31];
                        end else begin
                            for (int i = 0; i < 32; i++) res[i] = x[(i+m)%32];
                            c = x[m-1];
                        end
                    end
                endcase
            end
        end
        e.op = res;
        e.sc = c;
        e.fl = (c_en && !ls) ? c : ci;
        e.ad = ls && ins[23];
        return e;
    endfunction

    function automatic string tag_of(input logic [31:0] ins, input logic ls);
        if (ls && !ins[25]) return "R9";
        if (!ls && ins[4]) return "R7";
        case (ins[6:5])
            2'd0: return "R3";
            2'd1: return "R4";
            2'd2: return "R5";
            default: return "R6";
        endcase
    endfunction

    function automatic logic [31:0] mk_imm(input logic [1:0] k, input logic [4:0] n, input logic [3:0] r);
        return {20'd0, n, k, 1'b0, r};
    endfunction

    function automatic logic [31:0] mk_reg(input logic [1:0] k, input logic [3:0] s, input logic [3:0] r);
        return {20'd0, s, 1'b0, k, 1'b1, r};
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] ins, input logic [31:0] x, input logic [31:0] r,
                         input logic ci, input logic c_en, input logic ls);
        exp_t e;
        string t;
        @(negedge clk);
        instr = ins; rm = x; rs = r; cin = ci; cc = c_en; ldst = ls;
        #1;
        check("R2", "rm_idx", {28'd0, rm_idx}, {28'd0, ins[3:0]});
        check("R2", "rs_idx", {28'd0, rs_idx}, {28'd0, ins[11:8]});
        e = model(ins, x, r, ci, c_en, ls);
        t = tag_of(ins, ls);
        @(posedge clk);
        #1;
        check(t, "operand", operand, e.op);
        check(t, "shift carry", {31'd0, shc}, {31'd0, e.sc});
        check("R8", "carry flag", {31'd0, flag}, {31'd0, e.fl});
        check("R10", "offset add", {31'd0, add}, {31'd0, e.ad});
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] ins, x, r;
        logic [4:0]  n;
        logic        ci, c_en, ls;
        void'($urandom(32'h5EED_0A17));
        // R1: outputs held at zero under reset
        instr = mk_imm(2'd3, 5'd0, 4'd1); rm = 32'hFFFF_FFFF; cin = 1'b1; cc = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R1", "operand in reset", operand, 32'd0);
        check("R1", "flags in reset", {29'd0, shc, flag, add}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // directed corners of the zero immediate amount
        for (int k = 0; k < 4; k++) begin
            apply(mk_imm(2'(k), 5'd0, 4'd5), 32'h8000_0001, '0, 1'b0, 1'b1, 1'b0);
            apply(mk_imm(2'(k), 5'd0, 4'd5), 32'h8000_0001, '0, 1'b1, 1'b1, 1'b0);
            apply(mk_imm(2'(k), 5'd0, 4'd5), 32'h7FFF_FFFE, '0, 1'b1, 1'b1, 1'b0);
            apply(mk_imm(2'(k), 5'd1, 4'd5), 32'h8000_0001, '0, 1'b0, 1'b1, 1'b0);
            apply(mk_imm(2'(k), 5'd31, 4'd5), 32'hC000_0003, '0, 1'b0, 1'b1, 1'b0);
        end
        // register amounts at and beyond the word width
        for (int k = 0; k < 4; k++) begin
            apply(mk_reg(2'(k), 4'd2, 4'd3), 32'h8000_0001, 32'd0, 1'b1, 1'b1, 1'b0);
            apply(mk_reg(2'(k), 4'd2, 4'd3), 32'h8000_0001, 32'd32, 1'b0, 1'b1, 1'b0);
            apply(mk_reg(2'(k), 4'd2, 4'd3), 32'h8000_0001, 32'd33, 1'b0, 1'b1, 1'b0);
            apply(mk_reg(2'(k), 4'd2, 4'd3), 32'h8000_0001, 32'd64, 1'b0, 1'b1, 1'b0);
            apply(mk_reg(2'(k), 4'd2, 4'd3), 32'hA5A5_0F0F, 32'hFFFF_FF04, 1'b0, 1'b1, 1'b0);
        end
        // R8: no flag update without the flag-setting logical qualifier
        apply(mk_imm(2'd1, 5'd0, 4'd0), 32'h8000_0000, '0, 1'b0, 1'b0, 1'b0);
        // R9, R10: load/store immediate offset, both directions, and shifted offset with bit 4 set
        apply(32'h0080_0ABC, 32'hFFFF_FFFF, '0, 1'b1, 1'b1, 1'b1);
        apply(32'h0000_0FFF, 32'hFFFF_FFFF, '0, 1'b0, 1'b0, 1'b1);
        apply(32'h0280_0050 | mk_imm(2'd2, 5'd0, 4'd7), 32'h8000_0000, '0, 1'b0, 1'b1, 1'b1);

        // constrained random mix
        for (int it = 0; it < 3000; it++) begin
            ins  = $urandom();
            x    = $urandom();
            ci   = 1'($urandom());
            c_en = 1'($urandom());
            ls   = ($urandom_range(3) == 0);
            if ($urandom_range(3) == 0) ins[11:7] = 5'd0;
            n = 5'($urandom_range(6));
            case (n)
                5'd0: r = 32'd0;
                5'd1: r = 32'd32;
                5'd2: r = 32'd33;
                5'd3: r = {$urandom(), 8'd255} >> 0;
                5'd4: r = {24'($urandom()), 3'($urandom()), 5'd0};
                default: r = $urandom();
            endcase
            apply(ins, x, r, ci, c_en, ls);
        end

        // R1: asynchronous reset in mid-run clears the outputs
        @(negedge clk);
        instr = mk_imm(2'd2, 5'd0, 4'd1); rm = 32'hFFFF_FFFF; ldst = 1'b0; cc = 1'b1; cin = 1'b1;
        @(posedge clk);
        #1;
        rst_n = 1'b0;
        #1;
        check("R1", "operand after reset", operand, 32'd0);
        check("R1", "flags after reset", {29'd0, shc, flag, add}, 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule